// File: doc/BRIEF.md
# Multi-PHY Transmit Poller with Logical-to-Physical Address Remap

This block is the master-side address and selection engine for a shared-bus transmit interface of the UTOPIA Level-2 kind. Several physical devices hang off one 5-bit address bus. Each device watches the bus and answers with a single cell-available line when its own address is on it. The block cycles through a programmable number of logical ports. For each port it looks up the physical address in a writable table and drives it onto the bus. One cycle later it samples the device's answer and stores the result as that port's ready bit. Software reads the ready bits as a vector.

A client that wants to send a cell raises a request and names a logical port. It does not name a physical address. The block accepts the request only when that port's ready bit is set. It then spends one bus cycle driving the port's physical address, which selects the device, and pulses a launch strobe that hands off to the cell transmitter. The next bus cycle carries the all-ones null address. After that, polling resumes. Launching clears the port's ready bit, so a second cell waits until a fresh poll shows the device has room.

Top module: `mphy_tx_poller`

## Requirements
- R1: During and straight after reset, `phy_addr` is all ones, `port_ready` is zero and `tx_sel` is low. Table entry i holds physical address i. The active port count is `INIT_PORTS`.
- R2: A write with `cfg_addr` below `MAX_PORTS` sets that table entry to `cfg_wdata`. If `cfg_wdata` is all ones (the null address), the write is ignored.
- R3: A write to `cfg_addr` all ones sets the active port count N. The values 0 and values above `MAX_PORTS` are ignored. Ready bits of ports at or above N read 0.
- R4: With no launch in progress, one logical port is polled every cycle. `phy_addr` shows the table entry of ports 0, 1, …, N-1 in turn and wraps back to port 0.
- R5: A poll's `phy_clav` is taken from the cycle after the one in which its address is on `phy_addr`. It becomes the port's `port_ready` bit one cycle after that.
- R6: A request (`tx_req` with `tx_port`) is launched only if `tx_port` is below N and its ready bit is set. Otherwise it is held, and it launches once a later poll sets the bit. The client holds `tx_req` and `tx_port` steady until it sees `tx_sel`.
- R7: In a launch cycle, `tx_sel` is high, `tx_sel_port` equals the requested port, and `phy_addr` equals that port's table entry. In the same cycle the port's ready bit reads 0. It stays 0 until a poll that starts after the launch samples the device again; a poll already in flight for that port is discarded.
- R8: The cycle after a launch drives the null address, and `tx_sel` is low in it.
- R9: A table write takes effect at that port's next poll or launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CW = clog2(MAX_PORTS+1) | Table entry index, or all ones for the port count |
| cfg_wdata | input | ADDR_W | Physical address or port count |
| port_ready | output | MAX_PORTS | Polled ready bit per logical port |
| tx_req | input | 1 | Launch request, held until `tx_sel` |
| tx_port | input | PW = clog2(MAX_PORTS) | Logical port of the request |
| tx_sel | output | 1 | One-cycle launch strobe to the cell transmitter |
| tx_sel_port | output | PW | Logical port being launched |
| phy_addr | output | ADDR_W | Shared physical address bus; all ones means null |
| phy_clav | input | 1 | Cell-available answer from the addressed device |

## Verification
The bench builds the block with `MAX_PORTS` = 8, `ADDR_W` = 5 and the default `INIT_PORTS`. An 8-entry table lets it watch the full post-reset rotation and a five-port rotation wrap within a handful of cycles. Because the count register then sits at index 15, the gap between the table and the count register is exercised. A five-bit bus keeps the non-consecutive remap (3, 5, 7, 9, 22) and the null address 31 intact. The small port count also makes a shrink to three ports, and a request to a port beyond N, quick to reach.

// File: rtl/mphy_pkg.sv
package mphy_pkg;

    // What the shared address bus carries in the next cycle.
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_POLL = 2'd1,
        SLOT_SEL  = 2'd2
    } slot_e;

endpackage

// File: rtl/mphy_addr_map.sv
module mphy_addr_map #(
    parameter int MAX_PORTS = 31,
    parameter int ADDR_W    = 5,
    parameter int PW        = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PW-1:0]     wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PW-1:0]     rd_idx_a,
    output logic [ADDR_W-1:0] rd_addr_a,
    input  logic [PW-1:0]     rd_idx_b,
    output logic [ADDR_W-1:0] rd_addr_b
);

    localparam logic [ADDR_W-1:0] NULL_A = '1;

    logic [ADDR_W-1:0] map_q [MAX_PORTS];
    logic [ADDR_W-1:0] map_d [MAX_PORTS];

    always_comb begin
        map_d = map_q;
        if (wr_en && (wr_addr != NULL_A) && (int'(wr_idx) < MAX_PORTS)) begin
            map_d[wr_idx] = wr_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_PORTS; i++) begin
                map_q[i] <= ADDR_W'(i);
            end
        end else begin
            map_q <= map_d;
        end
    end

    assign rd_addr_a = (int'(rd_idx_a) < MAX_PORTS) ? map_q[rd_idx_a] : NULL_A;
    assign rd_addr_b = (int'(rd_idx_b) < MAX_PORTS) ? map_q[rd_idx_b] : NULL_A;

    // R2: a non-null write lands in the addressed entry
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != NULL_A && int'(wr_idx) < MAX_PORTS)
        |=> map_q[$past(wr_idx)] == $past(wr_addr));

    // R2: a null-address write leaves the entry untouched
    a_r2_null_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == NULL_A && int'(wr_idx) < MAX_PORTS)
        |=> map_q[$past(wr_idx)] == $past(map_q[wr_idx]));

endmodule

// File: rtl/mphy_poll_seq.sv
module mphy_poll_seq #(
    parameter int MAX_PORTS = 31,
    parameter int PW        = 5,
    parameter int CW        = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic [CW-1:0] nports,
    output logic [PW-1:0] idx
);

    logic [PW-1:0] idx_q, idx_d, cur;

    always_comb begin
        // After a shrink of the port count, an out-of-range index restarts at 0.
        cur   = (int'(idx_q) < int'(nports)) ? idx_q : '0;
        idx_d = idx_q;
        if (advance) begin
            idx_d = (int'(cur) + 1 >= int'(nports)) ? '0 : cur + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx = cur;

    // R4: the last active port is followed by port 0
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && int'(idx) + 1 == int'(nports)) |=> idx == '0);

    // R4: an advance step moves exactly one port forward
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && int'(idx) + 1 < int'(nports)) |=> idx_q == $past(idx) + 1'b1);

endmodule

// File: rtl/mphy_port_status.sv
module mphy_port_status #(
    parameter int MAX_PORTS = 31,
    parameter int PW        = 5,
    parameter int CW        = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_en,
    input  logic [PW-1:0]        cap_idx,
    input  logic                 cap_val,
    input  logic                 clr_en,
    input  logic [PW-1:0]        clr_idx,
    input  logic [CW-1:0]        nports,
    output logic [MAX_PORTS-1:0] status
);

    logic [MAX_PORTS-1:0] st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (cap_en && int'(cap_idx) < MAX_PORTS) st_d[cap_idx] = cap_val;
        // A launch beats a same-cycle capture: the sample predates the cell.
        if (clr_en && int'(clr_idx) < MAX_PORTS) st_d[clr_idx] = 1'b0;
        for (int i = 0; i < MAX_PORTS; i++) begin
            if (i >= int'(nports)) st_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q;

    // R5: at most one ready bit is raised per poll cycle
    a_r5_one_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q & ~$past(st_q)));

    // R7: a launched port reads not-ready afterwards
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && int'(clr_idx) < MAX_PORTS) |=> !st_q[$past(clr_idx)]);

endmodule

// File: rtl/mphy_tx_poller.sv
module mphy_tx_poller
    import mphy_pkg::*;
#(
    parameter  int MAX_PORTS  = 31,
    parameter  int ADDR_W     = 5,
    parameter  int INIT_PORTS = MAX_PORTS,
    localparam int PW         = (MAX_PORTS > 1) ? $clog2(MAX_PORTS) : 1,
    localparam int CW         = $clog2(MAX_PORTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CW-1:0]        cfg_addr,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    output logic [MAX_PORTS-1:0] port_ready,
    input  logic                 tx_req,
    input  logic [PW-1:0]        tx_port,
    output logic                 tx_sel,
    output logic [PW-1:0]        tx_sel_port,
    output logic [ADDR_W-1:0]    phy_addr,
    input  logic                 phy_clav
);

    localparam logic [CW-1:0]     CNT_SEL = '1;
    localparam logic [ADDR_W-1:0] NULL_A  = '1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;      // bus value this cycle
        logic              sel;       // this cycle is a launch
        logic [PW-1:0]     sel_port;
        logic              p1_v;      // poll address on the bus now
        logic [PW-1:0]     p1_port;
        logic              p2_v;      // poll answer on phy_clav now
        logic [PW-1:0]     p2_port;
        logic [CW-1:0]     nports;
    } state_t;

    state_t r_q, r_d;

    slot_e             slot;
    logic              tgt_ok;
    logic              map_we;
    logic [ADDR_W-1:0] sel_addr, poll_addr;
    logic [PW-1:0]     poll_idx;
    logic [MAX_PORTS-1:0] status;

    mphy_addr_map #(.MAX_PORTS(MAX_PORTS), .ADDR_W(ADDR_W), .PW(PW)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (map_we),
        .wr_idx    (PW'(cfg_addr)),
        .wr_addr   (cfg_wdata),
        .rd_idx_a  (tx_port),
        .rd_addr_a (sel_addr),
        .rd_idx_b  (poll_idx),
        .rd_addr_b (poll_addr)
    );

    mphy_poll_seq #(.MAX_PORTS(MAX_PORTS), .PW(PW), .CW(CW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (slot == SLOT_POLL),
        .nports  (r_q.nports),
        .idx     (poll_idx)
    );

    mphy_port_status #(.MAX_PORTS(MAX_PORTS), .PW(PW), .CW(CW)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (r_q.p2_v),
        .cap_idx (r_q.p2_port),
        .cap_val (phy_clav),
        .clr_en  (slot == SLOT_SEL),
        .clr_idx (tx_port),
        .nports  (r_q.nports),
        .status  (status)
    );

    always_comb begin
        r_d    = r_q;
        map_we = cfg_we && (int'(cfg_addr) < MAX_PORTS);

        tgt_ok = tx_req && (int'(tx_port) < int'(r_q.nports)) && status[tx_port];

        if (r_q.sel)     slot = SLOT_IDLE;
        else if (tgt_ok) slot = SLOT_SEL;
        else             slot = SLOT_POLL;

        unique case (slot)
            SLOT_SEL:  r_d.addr = sel_addr;
            SLOT_POLL: r_d.addr = poll_addr;
            default:   r_d.addr = NULL_A;
        endcase

        r_d.sel      = (slot == SLOT_SEL);
        r_d.sel_port = (slot == SLOT_SEL) ? tx_port : r_q.sel_port;

        r_d.p1_v    = (slot == SLOT_POLL);
        r_d.p1_port = poll_idx;
        // A poll of the launched port that is still on the wire is stale.
        r_d.p2_v    = r_q.p1_v && !((slot == SLOT_SEL) && (r_q.p1_port == tx_port));
        r_d.p2_port = r_q.p1_port;

        if (cfg_we && cfg_addr == CNT_SEL && cfg_wdata != '0
            && int'(cfg_wdata) <= MAX_PORTS) begin
            r_d.nports = CW'(cfg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.addr     <= NULL_A;
            r_q.nports   <= CW'(INIT_PORTS);
        end else begin
            r_q <= r_d;
        end
    end

    assign phy_addr    = r_q.addr;
    assign tx_sel      = r_q.sel;
    assign tx_sel_port = r_q.sel_port;
    assign port_ready  = status;

    // R8: a launch is followed by a null-address cycle without a launch
    a_r8_gap_after_sel: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sel |=> (phy_addr == NULL_A && !tx_sel));

    // R6: every launch answers a request for the same port
    a_r6_sel_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sel |-> ($past(tx_req) && $past(tx_port) == tx_sel_port));

    // R7: the launched port reads not-ready in the launch cycle
    a_r7_ready_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sel |-> !port_ready[tx_sel_port]);

    // R3: the port count stays within 1..MAX_PORTS
    a_r3_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.nports != '0) && (int'(r_q.nports) <= MAX_PORTS));

    // R1: null address and no launch while reset is held
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> (phy_addr == NULL_A && !tx_sel));

endmodule

// File: tb/tb_mphy_tx_poller.sv
module tb_mphy_tx_poller;

    localparam int MAXP = 8;
    localparam int AW   = 5;
    localparam int PW   = 3;
    localparam int CW   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [CW-1:0]   cfg_addr = '0;
    logic [AW-1:0]   cfg_wdata = '0;
    logic [MAXP-1:0] port_ready;
    logic            tx_req = 1'b0;
    logic [PW-1:0]   tx_port = '0;
    logic            tx_sel;
    logic [PW-1:0]   tx_sel_port;
    logic [AW-1:0]   phy_addr;
    logic            phy_clav;

    // Device model: each physical address answers with the previous cycle's bus value.
    logic [31:0]   dev_rdy = '0;
    logic [AW-1:0] prev_addr = '1;
    always @(posedge clk) prev_addr <= phy_addr;
    assign phy_clav = dev_rdy[prev_addr];

    always #10 clk = ~clk;

    mphy_tx_poller #(.MAX_PORTS(MAXP), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .port_ready(port_ready), .tx_req(tx_req),
        .tx_port(tx_port), .tx_sel(tx_sel), .tx_sel_port(tx_sel_port),
        .phy_addr(phy_addr), .phy_clav(phy_clav)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // All stimulus tasks start and end just after a falling edge.
    task automatic cfg_write(input int a, input int d);
        cfg_we    = 1'b1;
        cfg_addr  = CW'(a);
        cfg_wdata = AW'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic sync_to(input int a, input string tag);
        bit hit = 1'b0;
        for (int i = 0; i < 40 && !hit; i++) begin
            @(negedge clk);
            if (int'(phy_addr) == a) hit = 1'b1;
        end
        chk(tag, int'(hit), 1);
    endtask

    task automatic wait_sel(output bit hit);
        hit = 1'b0;
        for (int i = 0; i < 30 && !hit; i++) begin
            @(negedge clk);
            if (tx_sel) hit = 1'b1;
        end
    endtask

    // Remap table: {physical address, device ready}
    localparam logic [5:0] VEC [5] = '{
        {5'd3, 1'b1}, {5'd5, 1'b0}, {5'd7, 1'b1}, {5'd9, 1'b0}, {5'd22, 1'b1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R6 watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        bit hit;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 addr in reset", int'(phy_addr), 31);
        chk("R1 ready in reset", int'(port_ready), 0);
        chk("R1 sel in reset", int'(tx_sel), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first addr is port 0 identity", int'(phy_addr), 0);
        for (int k = 1; k < MAXP; k++) begin
            @(negedge clk);
            chk("R1 identity rotation", int'(phy_addr), k);
        end
        @(negedge clk);
        chk("R4 wrap after 8 ports", int'(phy_addr), 0);

        // Table walk: remap, device readiness, then five active ports
        for (int i = 0; i < 5; i++) begin
            cfg_write(i, int'(VEC[i][5:1]));
            dev_rdy[VEC[i][5:1]] = VEC[i][0];
        end
        cfg_write(15, 5);
        repeat (20) @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            chk("R5 R2 polled ready bit", int'(port_ready[i]), int'(VEC[i][0]));
        end
        chk("R3 inactive ports read 0", int'(port_ready[7:5]), 0);
        sync_to(3, "R4 find port 0");
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            chk("R4 remapped rotation", int'(phy_addr), int'(VEC[i % 5][5:1]));
        end

        // R2 null write ignored
        cfg_write(2, 31);
        sync_to(5, "R2 find port 1");
        @(negedge clk);
        chk("R2 null write ignored", int'(phy_addr), 7);

        // R3 illegal counts ignored
        cfg_write(15, 0);
        cfg_write(15, 9);
        sync_to(9, "R3 find port 3");
        @(negedge clk);
        chk("R3 illegal counts ignored", int'(phy_addr), 22);

        // R7 R8 launch to ready port 4
        tx_req = 1'b1; tx_port = 3'd4;
        wait_sel(hit);
        tx_req = 1'b0;
        chk("R7 launch happened", int'(hit), 1);
        chk("R7 launch addr", int'(phy_addr), 22);
        chk("R7 launch port", int'(tx_sel_port), 4);
        chk("R7 ready dropped", int'(port_ready[4]), 0);
        dev_rdy[22] = 1'b0;
        @(negedge clk);
        chk("R8 null after launch", int'(phy_addr), 31);
        chk("R8 no second launch", int'(tx_sel), 0);
        repeat (12) @(negedge clk);
        chk("R7 stays clear", int'(port_ready[4]), 0);
        dev_rdy[22] = 1'b1;
        repeat (12) @(negedge clk);
        chk("R7 repolled ready", int'(port_ready[4]), 1);

        // R6 held request to a not-ready port
        tx_req = 1'b1; tx_port = 3'd1;
        hit = 1'b0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (tx_sel) hit = 1'b1;
        end
        chk("R6 held while not ready", int'(hit), 0);
        dev_rdy[5] = 1'b1;
        wait_sel(hit);
        tx_req = 1'b0;
        chk("R6 launches once ready", int'(hit), 1);
        chk("R6 launched port", int'(tx_sel_port), 1);
        chk("R6 launched addr", int'(phy_addr), 5);

        // R6 port beyond the active count never launches
        dev_rdy[6] = 1'b1;
        tx_req = 1'b1; tx_port = 3'd6;
        hit = 1'b0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (tx_sel) hit = 1'b1;
        end
        tx_req = 1'b0;
        chk("R6 inactive port held", int'(hit), 0);

        // R3 shrink to three ports
        cfg_write(15, 3);
        repeat (10) @(negedge clk);
        chk("R3 shrunk ports read 0", int'(port_ready[4:3]), 0);
        hit = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (phy_addr == 5'd9 || phy_addr == 5'd22) hit = 1'b1;
        end
        chk("R4 only active ports polled", int'(hit), 0);

        // R9 remap port 0 to a not-ready device, then R5 exact sample cycle
        cfg_write(0, 12);
        repeat (10) @(negedge clk);
        chk("R9 remap takes effect", int'(port_ready[0]), 0);
        sync_to(12, "R9 new address polled");
        dev_rdy[12] = 1'b1;
        @(negedge clk);
        chk("R5 not yet updated", int'(port_ready[0]), 0);
        @(negedge clk);
        chk("R5 updated after answer cycle", int'(port_ready[0]), 1);

        finish_run();
    end

endmodule